// File: doc/BRIEF.md
# SPI Slave with Frame Direction Detection

This block is the serial side of a host interface. An external master drives SCK, an active-low select (NSS) and MOSI. The slave returns data on MISO in 8-bit words, most significant bit first. All three serial inputs are oversampled by the system clock through two-flop synchronizers. Edges are found in the system clock domain. For this reason SCK must run at no more than a quarter of the system clock rate. The local side sees a receive byte with a one-cycle valid strobe, a one-byte transmit holding register with a load input and a request output, a busy flag, and the detected frame direction.

Clock polarity, clock phase and the operating mode are written through a small configuration port. A write lands in a pending copy first. The pending copy is moved into the active copy only while no frame is in progress. In native mode the link runs full duplex: every byte received is delivered, and every byte shifted out comes from the holding register. In framed mode the link runs half duplex, and the first byte of each frame chooses the direction.

- A leading 0 bit marks a host write. The slave then drives all ones on MISO for the whole frame.
- A first byte of FFh marks a host read. The following bytes come from the holding register.
- Any other first byte is a framing error, and the rest of that frame is ignored.

Top module: `spi_slave_dirdet`

## Requirements
- R1: After reset, busy_o=0, rx_valid_o=0, tx_req_o=1, miso_o=1 and dir_o=00.
- R2: busy_o goes high after NSS falls and returns low after NSS rises. Each change appears a few system clocks after the pin changes, because of synchronizer latency.
- R3: Received bits are assembled MSB first. One complete byte produces exactly one rx_valid_o pulse, one system clock wide, with the byte on rx_data_o. This holds for all four settings of cpol and cpha.
- R4: In native mode (cfg_framed_i=0), MISO shifts out the held transmit byte MSB first, at the same time as reception, in all four clock modes. Bytes loaded during a frame are sent in later byte slots.
- R5: tx_req_o is high while the holding register is empty. It drops on the cycle after tx_load_i. It rises again once the byte is taken into the shifter. When a byte slot starts with the register empty, the slot sends FFh.
- R6: In framed mode, a first byte whose MSB is 0 sets dir_o=01 (host write). MISO then stays 1 for the whole frame, every received byte is delivered, and the holding register is not consumed.
- R7: In framed mode, a first byte of FFh sets dir_o=10 (host read). No received byte of that frame is delivered, and the following byte slots send the held transmit data.
- R8: In framed mode, a first byte that starts with 1 but is not FFh sets dir_o=11. No byte of that frame is delivered, MISO stays 1, and the holding register is not consumed.
- R9: A configuration write made while busy_o is high has no effect until busy_o is low. The ongoing frame keeps its old cpol, cpha and mode.
- R10: A rise on NSS clears the bit count and the direction, so dir_o=00 while idle. A partial byte is discarded, and the next frame starts on a byte boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for the pending configuration |
| cfg_cpol_i | input | 1 | Clock idle level |
| cfg_cpha_i | input | 1 | 0: sample on the leading edge, 1: sample on the trailing edge |
| cfg_framed_i | input | 1 | 0: native full duplex, 1: framed half duplex |
| sck_i | input | 1 | Serial clock from the master |
| nss_i | input | 1 | Slave select, active low |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master, 1 while idle |
| rx_data_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe marking a new received byte |
| tx_data_i | input | 8 | Byte for the holding register |
| tx_load_i | input | 1 | Writes tx_data_i into the holding register |
| tx_req_o | output | 1 | Holding register empty |
| busy_o | output | 1 | Frame in progress |
| dir_o | output | 2 | 00 undecided/idle, 01 host write, 10 host read, 11 framing error |

## Verification
Native transfers run through all four cpol/cpha pairings with asymmetric bytes such as A5h/3Ch, 80h and 01h. These patterns catch a mismatched sample edge, a swapped bit order and a loss of the first or last bit. In framed mode, three first bytes are applied: a leading 0, exactly FFh, and 81h. They separate the write, read and error branches, and each is observed through MISO, the delivered byte count and tx_req_o. A configuration write made mid-frame toward a mode with the opposite sample edge shows whether the lock holds. A three-bit aborted frame followed by a full byte shows whether NSS realigns the bit counter.

// File: rtl/spi_dd_pkg.sv
package spi_dd_pkg;
  typedef enum logic [1:0] {
    DIR_NONE = 2'b00,
    DIR_WR   = 2'b01,
    DIR_RD   = 2'b10,
    DIR_ERR  = 2'b11
  } dir_e;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic framed;
  } cfg_t;
endpackage

// File: rtl/spi_dd_sync.sv
module spi_dd_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic rise_o,
  output logic fall_o
);
  // one extra stage keeps the previous synchronized value for edge detect
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= {(STAGES+1){RST_VAL}};
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign q_o    = sh_q[STAGES-1];
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/spi_dd_cfg.sv
module spi_dd_cfg
  import spi_dd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  cfg_t wdata_i,
  input  logic lock_i,
  output cfg_t act_o
);
  cfg_t pend_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      if (we_i)    pend_q <= wdata_i;
      if (!lock_i) act_q  <= pend_q;
    end
  end

  assign act_o = act_q;

  a_r9_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable(act_q));
endmodule

// File: rtl/spi_dd_txbuf.sv
module spi_dd_txbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  logic              full_q;
  logic [DATA_W-1:0] buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      buf_q  <= '0;
    end else begin
      if (take_i) full_q <= 1'b0;
      if (load_i) begin
        full_q <= 1'b1;
        buf_q  <= data_i;
      end
    end
  end

  assign full_o = full_q;
  assign data_o = buf_q;

  a_r5_load_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> full_q);
endmodule

// File: rtl/spi_dd_core.sv
module spi_dd_core
  import spi_dd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cfg_t              cfg_i,
  input  logic              sck_rise_i,
  input  logic              sck_fall_i,
  input  logic              nss_fall_i,
  input  logic              nss_rise_i,
  input  logic              mosi_i,
  input  logic              tx_full_i,
  input  logic [DATA_W-1:0] tx_buf_i,
  output logic              tx_take_o,
  output logic              miso_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              busy_o,
  output dir_e              dir_o
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic              in_frame_q, first_q, need_load_q, rx_valid_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [DATA_W-1:0] rx_sh_q, tx_sh_q, rx_data_q;
  dir_e              dir_q;

  logic              smp_on_fall, smp_edge, sft_edge, byte_done;
  logic              use_tx, load_now, deliver;
  logic [DATA_W-1:0] rx_next, fill;

  assign smp_on_fall = cfg_i.cpol ^ cfg_i.cpha;
  assign smp_edge    = in_frame_q & (smp_on_fall ? sck_fall_i : sck_rise_i);
  assign sft_edge    = in_frame_q & (smp_on_fall ? sck_rise_i : sck_fall_i);
  assign rx_next     = {rx_sh_q[DATA_W-2:0], mosi_i};
  assign byte_done   = smp_edge && (bit_cnt_q == LAST_BIT);

  assign use_tx   = !cfg_i.framed || (dir_q == DIR_RD);
  assign fill     = (use_tx && tx_full_i) ? tx_buf_i : '1;
  assign load_now = !nss_rise_i &&
                    ((nss_fall_i && !cfg_i.cpha) || (!nss_fall_i && sft_edge && need_load_q));
  assign tx_take_o = load_now && use_tx && tx_full_i;

  always_comb begin
    if (!cfg_i.framed)  deliver = 1'b1;
    else if (first_q)   deliver = !rx_next[DATA_W-1];
    else                deliver = (dir_q == DIR_WR);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q  <= 1'b0;
      first_q     <= 1'b0;
      need_load_q <= 1'b0;
      bit_cnt_q   <= '0;
      rx_sh_q     <= '0;
      tx_sh_q     <= '1;
      dir_q       <= DIR_NONE;
      rx_valid_q  <= 1'b0;
      rx_data_q   <= '0;
    end else begin
      rx_valid_q <= 1'b0;
      if (nss_rise_i) begin
        in_frame_q  <= 1'b0;
        first_q     <= 1'b0;
        need_load_q <= 1'b0;
        bit_cnt_q   <= '0;
        tx_sh_q     <= '1;
        dir_q       <= DIR_NONE;
      end else if (nss_fall_i) begin
        in_frame_q  <= 1'b1;
        first_q     <= 1'b1;
        bit_cnt_q   <= '0;
        dir_q       <= DIR_NONE;
        need_load_q <= cfg_i.cpha;
        if (!cfg_i.cpha) tx_sh_q <= fill;
      end else begin
        if (smp_edge) begin
          rx_sh_q   <= rx_next;
          bit_cnt_q <= byte_done ? '0 : bit_cnt_q + 1'b1;
          if (byte_done) begin
            need_load_q <= 1'b1;
            first_q     <= 1'b0;
            rx_valid_q  <= deliver;
            rx_data_q   <= rx_next;
            if (cfg_i.framed && first_q) begin
              if (!rx_next[DATA_W-1])  dir_q <= DIR_WR;
              else if (&rx_next)       dir_q <= DIR_RD;
              else                     dir_q <= DIR_ERR;
            end
          end
        end
        if (sft_edge) begin
          if (need_load_q) begin
            tx_sh_q     <= fill;
            need_load_q <= 1'b0;
          end else begin
            tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b1};
          end
        end
      end
    end
  end

  assign miso_o     = in_frame_q ? tx_sh_q[DATA_W-1] : 1'b1;
  assign rx_data_o  = rx_data_q;
  assign rx_valid_o = rx_valid_q;
  assign busy_o     = in_frame_q;
  assign dir_o      = dir_q;

  a_r3_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_q |=> !rx_valid_q);
  a_r8_err_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_q == DIR_ERR) |-> !rx_valid_q);
  a_r6_wr_miso_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_frame_q && cfg_i.framed && dir_q != DIR_RD) |-> miso_o);
  a_r10_idle_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_frame_q |-> (dir_q == DIR_NONE));
endmodule

// File: rtl/spi_slave_dirdet.sv
module spi_slave_dirdet
  import spi_dd_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_cpol_i,
  input  logic              cfg_cpha_i,
  input  logic              cfg_framed_i,
  input  logic              sck_i,
  input  logic              nss_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_load_i,
  output logic              tx_req_o,
  output logic              busy_o,
  output logic [1:0]        dir_o
);
  logic sck_s, sck_rise, sck_fall;
  logic nss_s, nss_rise, nss_fall;
  logic mosi_s, mosi_rise_nc, mosi_fall_nc;
  logic busy, tx_full, tx_take;
  logic [DATA_W-1:0] tx_buf;
  cfg_t cfg_wr, cfg_act;
  dir_e dir;

  spi_dd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck (
    .clk_i, .rst_ni, .d_i(sck_i), .q_o(sck_s), .rise_o(sck_rise), .fall_o(sck_fall));
  spi_dd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_nss (
    .clk_i, .rst_ni, .d_i(nss_i), .q_o(nss_s), .rise_o(nss_rise), .fall_o(nss_fall));
  spi_dd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_mosi (
    .clk_i, .rst_ni, .d_i(mosi_i), .q_o(mosi_s), .rise_o(mosi_rise_nc), .fall_o(mosi_fall_nc));

  assign cfg_wr = '{cpol: cfg_cpol_i, cpha: cfg_cpha_i, framed: cfg_framed_i};

  spi_dd_cfg u_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .wdata_i(cfg_wr),
    .lock_i(busy | nss_fall), .act_o(cfg_act));

  spi_dd_txbuf #(.DATA_W(DATA_W)) u_txbuf (
    .clk_i, .rst_ni, .load_i(tx_load_i), .data_i(tx_data_i),
    .take_i(tx_take), .full_o(tx_full), .data_o(tx_buf));

  spi_dd_core #(.DATA_W(DATA_W)) u_core (
    .clk_i, .rst_ni, .cfg_i(cfg_act),
    .sck_rise_i(sck_rise), .sck_fall_i(sck_fall),
    .nss_fall_i(nss_fall), .nss_rise_i(nss_rise), .mosi_i(mosi_s),
    .tx_full_i(tx_full), .tx_buf_i(tx_buf), .tx_take_o(tx_take),
    .miso_o, .rx_data_o, .rx_valid_o, .busy_o(busy), .dir_o(dir));

  assign busy_o   = busy;
  assign tx_req_o = !tx_full;
  assign dir_o    = dir;

  a_r2_busy_needs_nss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> !nss_s);
endmodule

// File: tb/tb_spi_slave_dirdet.sv
module tb_spi_slave_dirdet;
  localparam int HP = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_we_i = 0, cfg_cpol_i = 0, cfg_cpha_i = 0, cfg_framed_i = 0;
  logic sck_i = 0, nss_i = 1, mosi_i = 0;
  logic miso_o, rx_valid_o, tx_load_i = 0, tx_req_o, busy_o;
  logic [7:0] rx_data_o, tx_data_i = 0;
  logic [1:0] dir_o;

  always #5 clk = ~clk;

  spi_slave_dirdet dut (
    .clk_i(clk), .rst_ni, .cfg_we_i, .cfg_cpol_i, .cfg_cpha_i, .cfg_framed_i,
    .sck_i, .nss_i, .mosi_i, .miso_o, .rx_data_o, .rx_valid_o,
    .tx_data_i, .tx_load_i, .tx_req_o, .busy_o, .dir_o);

  int total = 0, bad = 0, rx_cnt = 0;
  logic [7:0] rx_hist [4];
  logic cur_cpol = 0, cur_cpha = 0;
  bit done = 0;

  always @(negedge clk) if (rx_valid_o) begin
    rx_hist[rx_cnt % 4] = rx_data_o;
    rx_cnt++;
  end

  function automatic logic [7:0] rx_back(int k);
    return rx_hist[(rx_cnt - k) % 4];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(logic pol, logic pha, logic frm);
    @(negedge clk);
    cfg_we_i = 1; cfg_cpol_i = pol; cfg_cpha_i = pha; cfg_framed_i = frm;
    @(negedge clk);
    cfg_we_i = 0;
  endtask

  task automatic tx_load(logic [7:0] d);
    @(negedge clk);
    tx_data_i = d; tx_load_i = 1;
    @(negedge clk);
    tx_load_i = 0;
  endtask

  task automatic frame_start();
    sck_i = cur_cpol;
    wclk(4);
    nss_i = 0;
    wclk(HP);
  endtask

  task automatic frame_end();
    wclk(HP);
    nss_i = 1;
    wclk(8);
  endtask

  task automatic xfer(input logic [7:0] mo, input int nbits, output logic [7:0] mi);
    mi = '1;
    for (int i = 7; i > 7 - nbits; i--) begin
      if (!cur_cpha) begin
        mosi_i = mo[i]; wclk(HP);
        mi[i] = miso_o; sck_i = ~cur_cpol; wclk(HP);
        sck_i = cur_cpol;
      end else begin
        wclk(HP);
        sck_i = ~cur_cpol; mosi_i = mo[i]; wclk(HP);
        mi[i] = miso_o; sck_i = cur_cpol;
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // {cpol, cpha, mosi byte, tx byte}
  localparam logic [17:0] VEC [6] = '{
    {2'd0, 8'hA5, 8'h3C}, {2'd1, 8'h5A, 8'hC3}, {2'd2, 8'h80, 8'h01},
    {2'd3, 8'h01, 8'h80}, {2'd0, 8'hFF, 8'h00}, {2'd3, 8'h00, 8'hFF}};

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    logic [7:0] mi, mi2;
    int base;
    wclk(3);
    chk("R1 busy", busy_o, 0);
    chk("R1 miso", miso_o, 1);
    chk("R1 tx_req", tx_req_o, 1);
    chk("R1 rx_valid", rx_valid_o, 0);
    chk("R1 dir", dir_o, 0);
    rst_ni = 1;
    wclk(3);

    // R3/R4 native vectors in all four modes
    for (int v = 0; v < 6; v++) begin
      cur_cpol = VEC[v][17]; cur_cpha = VEC[v][16];
      cfg_write(cur_cpol, cur_cpha, 1'b0);
      tx_load(VEC[v][7:0]);
      chk("R5 req low after load", tx_req_o, 0);
      base = rx_cnt;
      frame_start();
      chk("R2 busy in frame", busy_o, 1);
      xfer(VEC[v][15:8], 8, mi);
      frame_end();
      chk("R2 busy after frame", busy_o, 0);
      chk("R4 miso byte", mi, VEC[v][7:0]);
      chk("R3 one valid", rx_cnt - base, 1);
      chk("R3 rx byte", rx_back(1), VEC[v][15:8]);
      chk("R5 req high after take", tx_req_o, 1);
    end

    // R4 two-byte native, second byte loaded mid-frame (mode 1)
    cur_cpol = 0; cur_cpha = 1;
    cfg_write(0, 1, 0);
    tx_load(8'h96);
    frame_start();
    xfer(8'h11, 8, mi);
    chk("R5 req after take", tx_req_o, 1);
    tx_load(8'h69);
    xfer(8'h22, 8, mi2);
    frame_end();
    chk("R4 byte1", mi, 8'h96);
    chk("R4 byte2", mi2, 8'h69);

    // R5 underrun
    base = rx_cnt;
    frame_start();
    xfer(8'h33, 8, mi);
    frame_end();
    chk("R5 underrun ff", mi, 8'hFF);
    chk("R5 req stays", tx_req_o, 1);

    // R6 framed write
    cur_cpol = 0; cur_cpha = 0;
    cfg_write(0, 0, 1);
    tx_load(8'h77);
    base = rx_cnt;
    frame_start();
    xfer(8'h3C, 8, mi);
    wclk(4);
    chk("R6 dir write", dir_o, 2'b01);
    xfer(8'hA5, 8, mi2);
    frame_end();
    chk("R6 miso b1", mi, 8'hFF);
    chk("R6 miso b2", mi2, 8'hFF);
    chk("R6 count", rx_cnt - base, 2);
    chk("R6 first", rx_back(2), 8'h3C);
    chk("R6 second", rx_back(1), 8'hA5);
    chk("R6 tx kept", tx_req_o, 0);
    chk("R10 dir idle", dir_o, 0);

    // R7 framed read (0x77 still held)
    base = rx_cnt;
    frame_start();
    xfer(8'hFF, 8, mi);
    wclk(4);
    chk("R7 dir read", dir_o, 2'b10);
    xfer(8'h12, 8, mi2);
    frame_end();
    chk("R7 first ff", mi, 8'hFF);
    chk("R7 tx data", mi2, 8'h77);
    chk("R7 no rx", rx_cnt - base, 0);
    chk("R7 taken", tx_req_o, 1);

    // R8 framing error
    tx_load(8'h44);
    base = rx_cnt;
    frame_start();
    xfer(8'h81, 8, mi);
    wclk(4);
    chk("R8 dir err", dir_o, 2'b11);
    xfer(8'h00, 8, mi2);
    frame_end();
    chk("R8 miso", mi2, 8'hFF);
    chk("R8 no rx", rx_cnt - base, 0);
    chk("R8 tx kept", tx_req_o, 0);
    chk("R10 dir cleared", dir_o, 0);

    // R9 config lock: mode 1 written mid-frame, mode 0 still used
    cfg_write(0, 0, 0);
    base = rx_cnt;
    frame_start();
    xfer(8'h5A, 8, mi);
    cfg_write(0, 1, 0);
    xfer(8'h3C, 8, mi);
    frame_end();
    chk("R9 count", rx_cnt - base, 2);
    chk("R9 old mode byte", rx_back(1), 8'h3C);
    cur_cpha = 1;
    base = rx_cnt;
    frame_start();
    xfer(8'hC3, 8, mi);
    frame_end();
    chk("R9 new mode byte", rx_back(1), 8'hC3);

    // R10 aborted partial byte
    base = rx_cnt;
    frame_start();
    xfer(8'hE0, 3, mi);
    frame_end();
    frame_start();
    xfer(8'h5C, 8, mi);
    frame_end();
    chk("R10 count", rx_cnt - base, 1);
    chk("R10 aligned", rx_back(1), 8'h5C);

    finish_run();
  end
endmodule